// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a 32-bit processor core that runs in several operating modes. Software names logical registers 0 to 14. The block maps each name to a physical copy chosen by the current mode. Some registers are shared by every mode. Others have private copies, so an exception handler can use its own stack pointer and return-address register without saving the interrupted code's values first.

There are two read ports and one ordinary write port. A separate bank of saved-status words gives each exception mode its own copy. The current mode is held inside the block and is changed only through a dedicated load strobe.

An exception-entry strobe names a target mode. In a single cycle it stores a return address into that mode's register 14 and a status word into that mode's saved-status copy. The status word is stored whole, so its layout is kept intact:
- mode in bits 4:0
- Thumb bit at 5
- fast-interrupt mask at 6
- interrupt mask at 7
- flags V, C, Z and N at bits 28 to 31

Top module: `banked_regfile`

## Requirements
- R1: Synchronous reset clears every physical register and every saved-status word, and sets the mode to supervisor (5'b10011). Read outputs are zero after reset.
- R2: Logical registers 0 to 7 are one physical set seen identically from every mode.
- R3: Logical registers 8 to 12 have one copy for the fast-interrupt mode (5'b10001) and a second copy shared by all other modes.
- R4: Logical registers 13 and 14 have a private copy in each exception mode: fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111 and undefined 5'b11011. User (5'b10000) and system (5'b11111) share one copy.
- R5: A mode value outside the seven encodings in R4 behaves exactly like user mode.
- R6: Each exception mode has its own saved-status word, readable and writable while that mode is current. In user, system or unlisted modes, a read returns zero and a write changes no saved-status word.
- R7: Read data appears one cycle after the address. A read of a register written in the same cycle returns the old value, and the new value is returned from the next cycle on.
- R8: An exception-entry strobe with an exception target mode loads that mode's register 14 and saved-status word in one cycle, whatever the current mode. A strobe whose target is user, system or unlisted has no effect.
- R9: When the exception-entry strobe and an ordinary write hit the same physical register or saved-status word in one cycle, the exception-entry value is kept.
- R10: Logical address 15 always reads zero, and a write to it changes no register.
- R11: The mode changes only when the mode-load strobe is high, and `cur_mode` always shows the stored mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load `mode_wdata` into the mode register |
| mode_wdata | input | 5 | New mode value |
| cur_mode | output | 5 | Current mode |
| wr_en | input | 1 | Ordinary register write enable |
| wr_addr | input | 4 | Logical register written |
| wr_data | input | 32 | Write data |
| rd_a_addr | input | 4 | Logical register for read port A |
| rd_a_data | output | 32 | Registered read data, port A |
| rd_b_addr | input | 4 | Logical register for read port B |
| rd_b_data | output | 32 | Registered read data, port B |
| spsr_we | input | 1 | Write the current mode's saved-status word |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_rdata | output | 32 | Registered saved-status word of the current mode |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of the exception entry |
| exc_ret_addr | input | 32 | Value loaded into the target mode's register 14 |
| exc_status | input | 32 | Value loaded into the target mode's saved-status word |

## Verification
Every one of the seven modes, plus one unlisted code, writes all fifteen logical registers and its saved-status word with a value that encodes the writer's mode and the register number. Every mode then reads every register back. The expected value is the one written by the last mode that shares the same copy, so the sweep separates the low, middle and high groups, tells fast-interrupt banking apart from the other exception modes, and confirms that user, system and unlisted modes share. Directed cases follow:
- exception entry from user mode, and with a user target;
- an exception entry colliding with an ordinary write;
- a read of a register written in the same cycle;
- address 15.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int LOW_REGS    = 8;
  localparam int MID_REGS    = 5;
  localparam int HIGH_REGS   = 2;
  localparam int NBANK       = 6;
  localparam int NEXC        = NBANK - 1;
  localparam int MID_BASE    = LOW_REGS;
  localparam int FIQMID_BASE = MID_BASE + MID_REGS;
  localparam int HIGH_BASE   = FIQMID_BASE + MID_REGS;
  localparam int HIGH_ADDR   = MID_BASE + MID_REGS;
  localparam int NLOGIC      = HIGH_ADDR + HIGH_REGS;
  localparam int NPHYS       = HIGH_BASE + NBANK * HIGH_REGS;
  localparam int PIDX_W      = $clog2(NPHYS);

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef logic [2:0] bank_t;
  localparam bank_t BANK_SHARED = 3'd0;
  localparam bank_t BANK_FIQ    = 3'd1;
  localparam bank_t BANK_IRQ    = 3'd2;
  localparam bank_t BANK_SVC    = 3'd3;
  localparam bank_t BANK_ABT    = 3'd4;
  localparam bank_t BANK_UND    = 3'd5;

  function automatic bank_t bank_of(logic [4:0] m);
    case (m)
      MODE_FIQ: return BANK_FIQ;
      MODE_IRQ: return BANK_IRQ;
      MODE_SVC: return BANK_SVC;
      MODE_ABT: return BANK_ABT;
      MODE_UND: return BANK_UND;
      default:  return BANK_SHARED;
    endcase
  endfunction
endpackage

// File: rtl/brf_bank_map.sv
module brf_bank_map
  import brf_pkg::*;
(
  input  bank_t             bank,
  input  logic [3:0]        addr,
  output logic [PIDX_W-1:0] idx,
  output logic              valid
);
  int sel;

  always_comb begin
    valid = 1'b1;
    sel   = 0;
    if (int'(addr) < MID_BASE) begin
      sel = int'(addr);
    end else if (int'(addr) < HIGH_ADDR) begin
      sel = (bank == BANK_FIQ) ? int'(addr) - MID_BASE + FIQMID_BASE : int'(addr);
    end else if (int'(addr) < NLOGIC) begin
      sel = HIGH_BASE + int'(bank) * HIGH_REGS + (int'(addr) - HIGH_ADDR);
    end else begin
      valid = 1'b0;
    end
    idx = PIDX_W'(sel);
  end

  // R4
  always_comb begin
    if (valid) idx_in_range_chk: assert (int'(idx) < NPHYS);
  end
endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store
  import brf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_a,
  input  logic [PIDX_W-1:0] wi_a,
  input  logic [DW-1:0]     wd_a,
  input  logic              we_x,
  input  logic [PIDX_W-1:0] wi_x,
  input  logic [DW-1:0]     wd_x,
  input  logic [PIDX_W-1:0] ri_a,
  input  logic              rv_a,
  input  logic [PIDX_W-1:0] ri_b,
  input  logic              rv_b,
  output logic [DW-1:0]     rd_a,
  output logic [DW-1:0]     rd_b
);
  logic [DW-1:0] mem [NPHYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
      rd_a <= '0;
      rd_b <= '0;
    end else begin
      rd_a <= rv_a ? mem[ri_a] : '0;
      rd_b <= rv_b ? mem[ri_b] : '0;
      if (we_a) mem[wi_a] <= wd_a;
      if (we_x) mem[wi_x] <= wd_x;
    end
  end

  // R10
  bad_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rv_a |=> (rd_a == '0));

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (we_a && !(we_x && wi_x == wi_a)) |=> (mem[$past(wi_a)] == $past(wd_a)));

  // R9
  exc_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (we_a && we_x && wi_x == wi_a) |=> (mem[$past(wi_x)] == $past(wd_x)));
endmodule

// File: rtl/brf_psr_bank.sv
module brf_psr_bank
  import brf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  bank_t         cur_bank,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          exc_we,
  input  bank_t         exc_bank,
  input  logic [DW-1:0] exc_data,
  output logic [DW-1:0] rdata
);
  logic [NEXC-1:0][DW-1:0] psr_q;
  logic cur_ok, exc_ok;

  assign cur_ok = (cur_bank != BANK_SHARED);
  assign exc_ok = exc_we && (exc_bank != BANK_SHARED);

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_q <= '0;
      rdata <= '0;
    end else begin
      rdata <= cur_ok ? psr_q[cur_bank - 3'd1] : '0;
      if (we && cur_ok) psr_q[cur_bank - 3'd1] <= wdata;
      if (exc_ok)       psr_q[exc_bank - 3'd1] <= exc_data;
    end
  end

  // R6
  shared_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !cur_ok |=> (rdata == '0));

  // R6
  shared_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!cur_ok && !exc_ok) |=> $stable(psr_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  logic [4:0]    mode_wdata,
  output logic [4:0]    cur_mode,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_addr,
  output logic [DW-1:0] rd_b_data,
  input  logic          spsr_we,
  input  logic [DW-1:0] spsr_wdata,
  output logic [DW-1:0] spsr_rdata,
  input  logic          exc_en,
  input  logic [4:0]    exc_mode,
  input  logic [DW-1:0] exc_ret_addr,
  input  logic [DW-1:0] exc_status
);
  localparam int NMAP = 4;

  logic [4:0] mode_q;
  bank_t      cur_bank, exc_bank;
  logic       exc_ok;

  bank_t             map_bank  [NMAP];
  logic [3:0]        map_addr  [NMAP];
  logic [PIDX_W-1:0] map_idx   [NMAP];
  logic              map_valid [NMAP];

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= MODE_SVC;
    else if (mode_we) mode_q <= mode_wdata;
  end
  assign cur_mode = mode_q;

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_we |=> $stable(mode_q));

  assign cur_bank = bank_of(mode_q);
  assign exc_bank = bank_of(exc_mode);
  assign exc_ok   = exc_en && (exc_bank != BANK_SHARED);

  // ports 0/1: reads, 2: ordinary write, 3: exception link register
  assign map_bank[0] = cur_bank;  assign map_addr[0] = rd_a_addr;
  assign map_bank[1] = cur_bank;  assign map_addr[1] = rd_b_addr;
  assign map_bank[2] = cur_bank;  assign map_addr[2] = wr_addr;
  assign map_bank[3] = exc_bank;  assign map_addr[3] = 4'(HIGH_ADDR + 1);

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    brf_bank_map u_map (
      .bank  (map_bank[g]),
      .addr  (map_addr[g]),
      .idx   (map_idx[g]),
      .valid (map_valid[g])
    );
  end

  brf_gpr_store #(.DW(DW)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we_a (wr_en && map_valid[2]),
    .wi_a (map_idx[2]),
    .wd_a (wr_data),
    .we_x (exc_ok),
    .wi_x (map_idx[3]),
    .wd_x (exc_ret_addr),
    .ri_a (map_idx[0]),
    .rv_a (map_valid[0]),
    .ri_b (map_idx[1]),
    .rv_b (map_valid[1]),
    .rd_a (rd_a_data),
    .rd_b (rd_b_data)
  );

  brf_psr_bank #(.DW(DW)) u_psr (
    .clk      (clk),
    .rst      (rst),
    .cur_bank (cur_bank),
    .we       (spsr_we),
    .wdata    (spsr_wdata),
    .exc_we   (exc_en),
    .exc_bank (exc_bank),
    .exc_data (exc_status),
    .rdata    (spsr_rdata)
  );
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        mode_we = 0;
  logic [4:0]  mode_wdata = 0;
  logic [4:0]  cur_mode;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [3:0]  rd_a_addr = 0, rd_b_addr = 0;
  logic [31:0] rd_a_data, rd_b_data;
  logic        spsr_we = 0;
  logic [31:0] spsr_wdata = 0, spsr_rdata;
  logic        exc_en = 0;
  logic [4:0]  exc_mode = 0;
  logic [31:0] exc_ret_addr = 0, exc_status = 0;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_regfile uut (.*);

  // mode list: usr fiq irq svc abt und sys, then one unlisted code
  localparam logic [4:0] MODES [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                       5'b10111, 5'b11011, 5'b11111, 5'b00110};

  function automatic int bench_bank(int mi);
    return (mi >= 1 && mi <= 5) ? mi : 0;
  endfunction

  function automatic int copy_class(int mi, int r);
    if (r < 8)  return 0;
    if (r < 13) return (mi == 1) ? 1 : 0;
    return 10 + bench_bank(mi);
  endfunction

  function automatic logic [31:0] sweep_val(int mi, int r);
    return 32'hA000_0000 | (32'(mi) << 8) | 32'(r);
  endfunction

  function automatic logic [31:0] sweep_expect(int mi, int r);
    int last = 0;
    for (int j = 0; j < 8; j++)
      if (copy_class(j, r) == copy_class(mi, r)) last = j;
    return sweep_val(last, r);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [4:0] m);
    @(negedge clk); mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_spsr(logic [31:0] d);
    @(negedge clk); spsr_we = 1; spsr_wdata = d;
    @(negedge clk); spsr_we = 0;
  endtask

  task automatic rd2(logic [3:0] a, logic [3:0] b);
    @(negedge clk); rd_a_addr = a; rd_b_addr = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 mode", {27'd0, cur_mode}, 32'h13);
    for (int r = 0; r < 15; r++) begin
      rd2(4'(r), 4'(r));
      chk("R1 reg", rd_a_data, 32'h0);
    end
    chk("R1 spsr", spsr_rdata, 32'h0);

    // sweep: each mode writes every register and its saved status
    for (int mi = 0; mi < 8; mi++) begin
      set_mode(MODES[mi]);
      chk("R11 mode", {27'd0, cur_mode}, {27'd0, MODES[mi]});
      for (int r = 0; r < 15; r++) wr(4'(r), sweep_val(mi, r));
      wr_spsr(32'h5000_0000 | 32'(mi));
    end

    // readback from every mode (R2 R3 R4 R5 R6)
    for (int mi = 0; mi < 8; mi++) begin
      set_mode(MODES[mi]);
      for (int r = 0; r < 15; r++) begin
        rd2(4'(r), 4'(14 - r));
        if (r < 8)       chk("R2 low", rd_a_data, sweep_expect(mi, r));
        else if (r < 13) chk("R3 mid", rd_a_data, sweep_expect(mi, r));
        else if (mi == 7) chk("R5 high", rd_a_data, sweep_expect(mi, r));
        else             chk("R4 high", rd_a_data, sweep_expect(mi, r));
        chk("R4 port b", rd_b_data, sweep_expect(mi, 14 - r));
      end
      chk("R6 spsr", spsr_rdata,
          bench_bank(mi) == 0 ? 32'h0 : (32'h5000_0000 | 32'(mi)));
    end

    // R8 exception entry into irq while in user mode
    set_mode(5'b10000);
    @(negedge clk); exc_en = 1; exc_mode = 5'b10010;
    exc_ret_addr = 32'h1234_5678; exc_status = 32'h8000_00D2;
    @(negedge clk); exc_en = 0;
    rd2(4'd14, 4'd13);
    chk("R8 user r14 kept", rd_a_data, sweep_expect(0, 14));
    // R8 user target ignored
    @(negedge clk); exc_en = 1; exc_mode = 5'b10000; exc_ret_addr = 32'hDEAD_BEEF;
    @(negedge clk); exc_en = 0;
    rd2(4'd14, 4'd13);
    chk("R8 user target ignored", rd_a_data, sweep_expect(0, 14));
    set_mode(5'b10010);
    rd2(4'd14, 4'd13);
    chk("R8 irq r14", rd_a_data, 32'h1234_5678);
    chk("R8 irq r13", rd_b_data, sweep_val(2, 13));
    chk("R8 irq spsr", spsr_rdata, 32'h8000_00D2);

    // R9 collision: exception and ordinary write to irq r14 and spsr
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd14; wr_data = 32'h1111_1111;
    spsr_we = 1; spsr_wdata = 32'h2222_2222;
    exc_en = 1; exc_mode = 5'b10010;
    exc_ret_addr = 32'h3333_3333; exc_status = 32'h4444_4444;
    @(negedge clk); wr_en = 0; spsr_we = 0; exc_en = 0;
    rd2(4'd14, 4'd0);
    chk("R9 r14", rd_a_data, 32'h3333_3333);
    chk("R9 spsr", spsr_rdata, 32'h4444_4444);

    // R7 same-cycle write and read
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd5; wr_data = 32'hCAFE_0005; rd_a_addr = 4'd5;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
    chk("R7 old value", rd_a_data, sweep_expect(2, 5));
    @(posedge clk);
    @(negedge clk);
    chk("R7 new value", rd_a_data, 32'hCAFE_0005);

    // R10 address 15
    wr(4'd15, 32'hFFFF_FFFF);
    rd2(4'd15, 4'd14);
    chk("R10 read zero", rd_a_data, 32'h0);
    chk("R10 no side effect", rd_b_data, 32'h3333_3333);
    for (int r = 0; r < 15; r++) begin
      rd2(4'(r), 4'd15);
      if (r != 5 && r != 14) chk("R10 regs intact", rd_a_data, sweep_expect(2, r));
      chk("R10 read zero b", rd_b_data, 32'h0);
    end

    // R11 mode held without strobe
    @(negedge clk); mode_wdata = 5'b10111;
    repeat (2) @(negedge clk);
    chk("R11 held", {27'd0, cur_mode}, 32'h12);

    done = 1;
    summary();
    $finish;
  end
endmodule